// File: doc/BRIEF.md
# Saturating Arithmetic Unit

This unit applies clamping arithmetic to 32-bit words. An issued operation computes a result that stays inside a fixed range instead of wrapping. The operations are signed and unsigned add and subtract, signed doubling, and clamping of a word to a chosen bit width. The width clamp comes in signed and unsigned flavours, and also in a packed form where each 16-bit half is clamped independently. Every clamp event raises a single shared sticky flag. Arithmetic never lowers that flag. Only an explicit clear input or reset brings it back to 0.

The result and the flag are registered, so each issued operation shows on the outputs one clock later. When no operation is issued, the result register and the flag keep their values, although a clear request is still honoured. The width field is 5 bits wide. Its legal range for each operation is a usage rule, and the hardware does not check it.

Top module: `sat_alu`

## Requirements
- R1: After reset, `result` is 0 and `sat_flag` is 0.
- R2: Op code 0 (signed add) returns a+b. When both operands share a sign and the sum's sign differs from it, the result is instead 0x7FFFFFFF if a is non-negative and 0x80000000 if a is negative.
- R3: Op code 1 (signed subtract) returns a-b. When the operand signs differ and the difference's sign differs from a's, the result clamps by a's sign in the same way as R2.
- R4: Op code 2 (doubling of a) gives 0x7FFFFFFF for signed a >= 0x40000000 and 0x80000000 for signed a <= 0xC0000000. The lower bound includes 0xC0000000 itself, which counts as a clamp. Any other a gives a shifted left by one.
- R5: Op code 3 (unsigned add) gives 0xFFFFFFFF on carry out. Op code 4 (unsigned subtract) gives 0 when b > a. Otherwise each gives the modular result.
- R6: Op code 5 (signed width clamp, s = width, 0..31) limits signed a to the range -2^s .. 2^s-1. Values inside the range pass through unchanged.
- R7: Op code 6 (unsigned width clamp, s = 0..31) gives 0 for negative a and 2^s-1 for a > 2^s-1. Other values pass through.
- R8: Op codes 7 and 8 apply R6 and R7 respectively to each sign-extended 16-bit half of a, with s = 0..15. Each half's low 16 bits are packed back into its own position.
- R9: A clamp in any operation sets `sat_flag`. No operation ever clears it.
- R10: `flag_clr` clears `sat_flag` on the next edge. If an operation issued in the same cycle clamps, the flag ends up 1.
- R11: Outputs update one cycle after an issue with `op_en` high. With `op_en` low, `result` holds and only `flag_clr` can change `sat_flag`.
- R12: Op codes 9..15 produce result 0 and never set the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_en | input | 1 | Issue strobe: operation is taken this cycle |
| op_sel | input | 4 | Operation code (see R2..R12) |
| opa | input | 32 | Operand a |
| opb | input | 32 | Operand b (add/subtract only) |
| width | input | 5 | Width parameter s for the clamp operations |
| flag_clr | input | 1 | Clears the sticky flag |
| result | output | 32 | Registered result |
| sat_flag | output | 1 | Sticky clamp flag |

## Verification
The bench sweeps every pair of sign-boundary operands through the add and subtract codes. A design that detected overflow from the carry instead of the signs would clamp 0xFFFFFFFF+1 or miss 0x7FFFFFFF+1. Doubling is driven at 0x40000000, 0x3FFFFFFF, 0xC0000001 and exactly 0xC0000000. A purely arithmetic range check would leave the flag low at 0xC0000000, where R4 requires it set. The width clamps are swept across every s with values just inside and outside each limit. An off-by-one limit, or a packed form that let one half's sign reach the other, shows up in the result or the flag. Separate sequences check that a clear coinciding with a clamp leaves the flag set, and that idle or unused-code cycles neither set nor drop it.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [3:0] {
    OP_SADD   = 4'd0,
    OP_SSUB   = 4'd1,
    OP_SDBL   = 4'd2,
    OP_UADD   = 4'd3,
    OP_USUB   = 4'd4,
    OP_SSATW  = 4'd5,
    OP_USATW  = 4'd6,
    OP_SSAT16 = 4'd7,
    OP_USAT16 = 4'd8
  } sat_op_e;

  localparam logic [3:0] OP_LAST = 4'd8;
endpackage

// File: rtl/sat_arith.sv
module sat_arith
  import sat_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         clamp
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] QPOS = {2'b01, {(W-2){1'b0}}};
  localparam logic [W-1:0] QNEG = {2'b11, {(W-2){1'b0}}};

  logic [W:0]   usum;
  logic [W-1:0] sum, dif, sclamp;

  assign usum   = {1'b0, a} + {1'b0, b};
  assign sum    = usum[W-1:0];
  assign dif    = a - b;
  assign sclamp = a[W-1] ? SMIN : SMAX;

  always_comb begin
    res   = '0;
    clamp = 1'b0;
    case (op)
      OP_SADD: begin
        clamp = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
        res   = clamp ? sclamp : sum;
      end
      OP_SSUB: begin
        clamp = (a[W-1] != b[W-1]) && (dif[W-1] != a[W-1]);
        res   = clamp ? sclamp : dif;
      end
      OP_SDBL: begin
        if ($signed(a) >= $signed(QPOS)) begin
          clamp = 1'b1;
          res   = SMAX;
        end else if ($signed(a) <= $signed(QNEG)) begin
          clamp = 1'b1;
          res   = SMIN;
        end else begin
          res = {a[W-2:0], 1'b0};
        end
      end
      OP_UADD: begin
        clamp = usum[W];
        res   = clamp ? '1 : sum;
      end
      OP_USUB: begin
        clamp = (b > a);
        res   = clamp ? '0 : dif;
      end
      default: begin
        res   = '0;
        clamp = 1'b0;
      end
    endcase
  end

  always_comb begin
    if (op == OP_SADD && clamp)
      assert_sadd_samesign_R2: assert (a[W-1] == b[W-1]);
    if (op == OP_SSUB && clamp)
      assert_ssub_diffsign_R3: assert (a[W-1] != b[W-1]);
  end
endmodule

// File: rtl/sat_width.sv
module sat_width #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  input  logic [SW-1:0] s,
  input  logic          sgn,
  output logic [W-1:0]  res,
  output logic          clamp
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0]        maxv;
  logic signed [W-1:0] top;

  assign maxv = (ONE << s) - ONE;
  assign top  = $signed(val) >>> s;

  always_comb begin
    res   = val;
    clamp = 1'b0;
    if (sgn) begin
      if (!top[W-1] && (top != '0)) begin
        res   = maxv;
        clamp = 1'b1;
      end else if (top[W-1] && (top != '1)) begin
        res   = ~maxv;
        clamp = 1'b1;
      end
    end else begin
      if (val[W-1]) begin
        res   = '0;
        clamp = 1'b1;
      end else if (val > maxv) begin
        res   = maxv;
        clamp = 1'b1;
      end
    end
  end

  always_comb begin
    if (sgn && (s == SW'(W-1)))
      assert_topwidth_noclamp_R6: assert (!clamp);
  end
endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_en,
  input  logic [3:0]      op_sel,
  input  logic [DW-1:0]   opa,
  input  logic [DW-1:0]   opb,
  input  logic [$clog2(DW)-1:0] width,
  input  logic            flag_clr,
  output logic [DW-1:0]   result,
  output logic            sat_flag
);
  localparam int SW  = $clog2(DW);
  localparam int HW  = DW / 2;
  localparam int HSW = $clog2(HW);

  logic [DW-1:0] ar_res, fw_res, hp_res, res_nx, result_d;
  logic          ar_clamp, fw_clamp, clamp_nx, flag_d;
  logic [1:0]    hp_clamp;
  logic          fw_sgn, hp_sgn;

  assign fw_sgn = (op_sel == OP_SSATW);
  assign hp_sgn = (op_sel == OP_SSAT16);

  sat_arith #(.W(DW)) u_arith (
    .op    (op_sel),
    .a     (opa),
    .b     (opb),
    .res   (ar_res),
    .clamp (ar_clamp)
  );

  sat_width #(.W(DW), .SW(SW)) u_full (
    .val   (opa),
    .s     (width),
    .sgn   (fw_sgn),
    .res   (fw_res),
    .clamp (fw_clamp)
  );

  for (genvar g = 0; g < 2; g++) begin : g_half
    sat_width #(.W(HW), .SW(HSW)) u_half (
      .val   (opa[g*HW +: HW]),
      .s     (width[HSW-1:0]),
      .sgn   (hp_sgn),
      .res   (hp_res[g*HW +: HW]),
      .clamp (hp_clamp[g])
    );
  end

  always_comb begin
    case (op_sel)
      OP_SADD, OP_SSUB, OP_SDBL, OP_UADD, OP_USUB: begin
        res_nx   = ar_res;
        clamp_nx = ar_clamp;
      end
      OP_SSATW, OP_USATW: begin
        res_nx   = fw_res;
        clamp_nx = fw_clamp;
      end
      OP_SSAT16, OP_USAT16: begin
        res_nx   = hp_res;
        clamp_nx = |hp_clamp;
      end
      default: begin
        res_nx   = '0;
        clamp_nx = 1'b0;
      end
    endcase
  end

  always_comb begin
    result_d = op_en ? res_nx : result;
    flag_d   = (sat_flag & ~flag_clr) | (op_en & clamp_nx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result   <= '0;
      sat_flag <= 1'b0;
    end else begin
      result   <= result_d;
      sat_flag <= flag_d;
    end
  end

  assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !flag_clr) |=> sat_flag);

  assert_clear_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !op_en) |=> !sat_flag);

  assert_idle_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !op_en |=> $stable(result));

  assert_idle_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_en && !flag_clr) |=> $stable(sat_flag));

  assert_unused_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && (op_sel > OP_LAST)) |=> (result == '0));
endmodule

// File: tb/sat_alu_bench.sv
module sat_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_en;
  logic [3:0]  op_sel;
  logic [31:0] opa, opb;
  logic [4:0]  width;
  logic        flag_clr;
  logic [31:0] result;
  logic        sat_flag;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sat_alu u_sat_alu (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_en    (op_en),
    .op_sel   (op_sel),
    .opa      (opa),
    .opb      (opb),
    .width    (width),
    .flag_clr (flag_clr),
    .result   (result),
    .sat_flag (sat_flag)
  );

  localparam logic [31:0] CORN [12] = '{
    32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
    32'h8000_0000, 32'h4000_0000, 32'hC000_0000, 32'h3FFF_FFFF,
    32'hC000_0001, 32'h1234_5678, 32'hFFFF_0000, 32'h8000_0001
  };
  localparam logic [15:0] HALF [8] = '{
    16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
    16'hFFFF, 16'h00FF, 16'hFF00, 16'h1234
  };

  function automatic logic [32:0] clamp_s(longint v, int s);
    longint lim = 64'sd1 <<< s;
    if (v > lim - 1) return {1'b1, 32'(lim - 1)};
    if (v < -lim)    return {1'b1, 32'(-lim)};
    return {1'b0, 32'(v)};
  endfunction

  function automatic logic [32:0] clamp_u(longint v, int s);
    longint lim = 64'sd1 <<< s;
    if (v < 0)       return {1'b1, 32'd0};
    if (v > lim - 1) return {1'b1, 32'(lim - 1)};
    return {1'b0, 32'(v)};
  endfunction

  function automatic logic [32:0] ref_op(logic [3:0] op, logic [31:0] a,
                                         logic [31:0] b, int s);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint ua = longint'({32'd0, a});
    longint ub = longint'({32'd0, b});
    logic [32:0] lo, hi;
    case (op)
      4'd0: return clamp_s(sa + sb, 31);
      4'd1: return clamp_s(sa - sb, 31);
      4'd2: begin
        if (sa >= 64'sh4000_0000)  return {1'b1, 32'h7FFF_FFFF};
        if (sa <= -64'sh4000_0000) return {1'b1, 32'h8000_0000};
        return {1'b0, 32'(2 * sa)};
      end
      4'd3: return (ua + ub > 64'sh FFFF_FFFF) ? {1'b1, 32'hFFFF_FFFF}
                                                : {1'b0, 32'(ua + ub)};
      4'd4: return (ub > ua) ? {1'b1, 32'd0} : {1'b0, 32'(ua - ub)};
      4'd5: return clamp_s(sa, s);
      4'd6: return clamp_u(sa, s);
      4'd7, 4'd8: begin
        longint h0 = longint'($signed(a[15:0]));
        longint h1 = longint'($signed(a[31:16]));
        lo = (op == 4'd7) ? clamp_s(h0, s) : clamp_u(h0, s);
        hi = (op == 4'd7) ? clamp_s(h1, s) : clamp_u(h1, s);
        return {lo[32] | hi[32], hi[15:0], lo[15:0]};
      end
      default: return 33'd0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h (op=%0d a=%08h b=%08h s=%0d)",
               req, got, exp, op_sel, opa, opb, width);
    end
  endtask

  // drive at a negedge, capture on the posedge, sample at the next negedge
  task automatic issue(logic en, logic [3:0] op, logic [31:0] a,
                       logic [31:0] b, int s, logic clr);
    op_en = en; op_sel = op; opa = a; opb = b; width = 5'(s); flag_clr = clr;
    @(negedge clk);
  endtask

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3, 4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic sweep_one(logic [3:0] op, logic [31:0] a, logic [31:0] b, int s);
    logic [32:0] e;
    e = ref_op(op, a, b, s);
    issue(1'b1, op, a, b, s, 1'b1);
    check(req_of(op), result, e[31:0]);
    check({req_of(op), "/R10 flag"}, {31'd0, sat_flag}, {31'd0, e[32]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_en = 1'b0; op_sel = '0; opa = '0; opb = '0;
    width = '0; flag_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 result", result, 32'd0);
    check("R1 flag", {31'd0, sat_flag}, 32'd0);

    // R2 R3 R4 R5: operand pair sweep
    for (int op = 0; op < 5; op++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          sweep_one(4'(op), CORN[i], CORN[j], 0);

    // R6 R7: every width with boundary values
    for (int op = 5; op < 7; op++)
      for (int s = 0; s < 32; s++) begin
        for (int i = 0; i < 12; i++) sweep_one(4'(op), CORN[i], 32'd0, s);
        sweep_one(4'(op), (32'd1 << s), 32'd0, s);
        sweep_one(4'(op), (32'd1 << s) - 32'd1, 32'd0, s);
        sweep_one(4'(op), -(32'd1 << s), 32'd0, s);
        sweep_one(4'(op), -(32'd1 << s) - 32'd1, 32'd0, s);
      end

    // R8: packed halves
    for (int op = 7; op < 9; op++)
      for (int s = 0; s < 16; s++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            sweep_one(4'(op), {HALF[i], HALF[j]}, 32'd0, s);

    // R9: sticky across non-clamping work
    issue(1'b1, 4'd0, 32'd1, 32'd1, 0, 1'b1);
    check("R10 clear", {31'd0, sat_flag}, 32'd0);
    issue(1'b1, 4'd3, 32'hFFFF_FFFF, 32'd2, 0, 1'b0);
    check("R9 set", {31'd0, sat_flag}, 32'd1);
    check("R5 uadd", result, 32'hFFFF_FFFF);
    issue(1'b1, 4'd0, 32'd5, 32'd6, 0, 1'b0);
    check("R9 sticky", {31'd0, sat_flag}, 32'd1);
    check("R2 plain", result, 32'd11);

    // R11: idle with clamping operands changes nothing
    issue(1'b0, 4'd0, 32'h7FFF_FFFF, 32'd1, 0, 1'b0);
    check("R11 hold result", result, 32'd11);
    check("R11 hold flag", {31'd0, sat_flag}, 32'd1);
    issue(1'b0, 4'd0, 32'h7FFF_FFFF, 32'd1, 0, 1'b1);
    check("R10 idle clear", {31'd0, sat_flag}, 32'd0);
    check("R11 hold result", result, 32'd11);
    issue(1'b0, 4'd4, 32'd0, 32'd9, 0, 1'b0);
    check("R11 idle no set", {31'd0, sat_flag}, 32'd0);

    // R12: unused codes
    issue(1'b1, 4'd9, 32'h7FFF_FFFF, 32'd1, 3, 1'b0);
    check("R12 result", result, 32'd0);
    check("R12 no set", {31'd0, sat_flag}, 32'd0);
    issue(1'b1, 4'd2, 32'h4000_0000, 32'd0, 0, 1'b0);
    check("R4 set", {31'd0, sat_flag}, 32'd1);
    issue(1'b1, 4'd15, 32'h8000_0000, 32'hFFFF_FFFF, 31, 1'b0);
    check("R12 result", result, 32'd0);
    check("R12/R9 kept", {31'd0, sat_flag}, 32'd1);

    // R10: clear and clamp in one cycle
    issue(1'b1, 4'd4, 32'd1, 32'd2, 0, 1'b1);
    check("R10 clamp wins", {31'd0, sat_flag}, 32'd1);
    issue(1'b1, 4'd4, 32'd2, 32'd1, 0, 1'b1);
    check("R10 clear", {31'd0, sat_flag}, 32'd0);
    check("R5 usub", result, 32'd1);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule